// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves transmit data out of memory by following a circular table of buffer descriptors. Each descriptor names a buffer in data memory, gives its own byte length, and carries three flags: one that says the buffer is ready to send, one that marks the last entry of the ring, and one that says this buffer closes a frame. The engine fetches the descriptor at its current pointer. If the descriptor is not ready, the engine keeps reading it again until software sets the ready flag. Once the descriptor is ready, the engine reads the buffer one byte at a time and hands each byte to a serial transmitter over a valid/ready handshake.

When the byte count of a buffer runs out, the engine writes the descriptor back with its ready flag cleared. It then moves to the next entry, or returns to the programmable ring base after an entry flagged as last in the ring or after the final slot of the table. A buffer that ends a frame has its final byte tagged as end-of-frame. Software may reposition the descriptor pointer only while the engine is disabled and at rest.

Top module: `tdr_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the descriptor pointer equals `cfg_ring_base`, `tx_valid` is low, and no memory request is issued while `cfg_enable` is low.
- R2: A descriptor word is 51 bits wide: bit 50 is ready, bit 49 is ring-wrap, bit 48 is end-of-frame, bits 47:32 are the byte length, and bits 31:0 are the buffer byte address.
- R3: For a ready descriptor, the engine reads exactly length bytes from consecutive addresses, starting at the buffer address. The read address always holds the next byte to fetch. The bytes reach `tx_data` in the same order.
- R4: Both read ports return data one cycle after the request. At most one data read is outstanding, so `mem_rd_en` is never high on two consecutive cycles.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: `tx_last` is high only on the final byte of a buffer whose end-of-frame bit is set.
- R7: After a buffer is fully sent, the engine writes the descriptor back to the same index with bit 50 cleared and all other bits unchanged.
- R8: A ready descriptor with length zero is written back at once, and no data memory read is made for it.
- R9: A descriptor whose ready bit is clear produces no bytes and no write-back. The pointer stays on it while the engine polls it.
- R10: After a descriptor with the ring-wrap bit, or one at the highest table index, is closed, the pointer becomes `cfg_ring_base`. Otherwise the pointer advances by one.
- R11: A host write to the pointer takes effect only while `cfg_enable` is low and the engine is idle. While enabled, such a write is ignored.
- R12: When `cfg_enable` is low and the engine has reached idle, no descriptor or data reads are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_ring_base | input | DPTR_W | Index of the first ring entry |
| host_ptr_we | input | 1 | Host write strobe for the descriptor pointer |
| host_ptr_wdata | input | DPTR_W | New descriptor pointer value |
| desc_ptr | output | DPTR_W | Current descriptor pointer |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_addr | output | DPTR_W | Descriptor read index |
| desc_rd_data | input | 51 | Descriptor word, one cycle after request |
| desc_wr_en | output | 1 | Descriptor write-back strobe |
| desc_wr_addr | output | DPTR_W | Descriptor write index |
| desc_wr_data | output | 51 | Descriptor word written back |
| mem_rd_en | output | 1 | Data byte read request |
| mem_rd_addr | output | 32 | Data byte address |
| mem_rd_data | input | 8 | Data byte, one cycle after request |
| tx_valid | output | 1 | Byte available to transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Transmitter accepts byte |

## Verification
The bench targets these corner cases:
- A zero-length entry in the middle of a ring. A design that reads from that entry anyway shows up as a surplus data read.
- A ring that ends on a wrap-flagged entry, and a ring that runs off the top slot of the table. Wrong wrap logic leaves the pointer away from the base.
- A descriptor that only becomes ready while the engine is already polling it. An engine that skips the entry, or writes it back early, produces a stray write-back.
- A pointer write issued while the engine is enabled. If that write is accepted, the pointer moves.

Random backpressure on `tx_ready` exposes data that changes while stalled, and end-of-frame flags placed on the wrong byte.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int LEN_W  = 16;
  localparam int BUF_AW = 32;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              ready;
    logic              wrap;
    logic              eof;
    logic [LEN_W-1:0]  len;
    logic [BUF_AW-1:0] buf_addr;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_BREQ, ST_BWAIT, ST_BSEND, ST_CLOSE
  } eng_state_t;
endpackage

// File: rtl/tdr_ptr.sv
module tdr_ptr #(
  parameter int DPTR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DPTR_W-1:0] base,
  input  logic              host_we,
  input  logic              host_ok,
  input  logic [DPTR_W-1:0] host_wdata,
  input  logic              adv,
  input  logic              wrap_flag,
  output logic [DPTR_W-1:0] ptr
);
  localparam logic [DPTR_W-1:0] TOP_IDX = {DPTR_W{1'b1}};

  logic [DPTR_W-1:0] next_idx;

  always_comb begin
    if (wrap_flag || ptr == TOP_IDX) next_idx = base;
    else                             next_idx = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                       ptr <= base;
    else if (adv)                  ptr <= next_idx;
    else if (host_we && host_ok)   ptr <= host_wdata;
  end
endmodule

// File: rtl/tdr_fetch.sv
module tdr_fetch #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          step,
  output logic [AW-1:0] rd_addr,
  output logic          remain_zero
);
  logic [LW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr <= '0;
      remain  <= '0;
    end else if (load) begin
      rd_addr <= ld_addr;
      remain  <= ld_len;
    end else if (step) begin
      rd_addr <= rd_addr + 1'b1;
      remain  <= remain - 1'b1;
    end
  end

  assign remain_zero = (remain == '0);
endmodule

// File: rtl/tdr_txreg.sv
module tdr_txreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_last,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ld_data;
      last  <= ld_last;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
  import tdr_pkg::*;
#(
  parameter int DPTR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_enable,
  input  logic [DPTR_W-1:0]     cfg_ring_base,
  input  logic                  host_ptr_we,
  input  logic [DPTR_W-1:0]     host_ptr_wdata,
  output logic [DPTR_W-1:0]     desc_ptr,
  output logic                  desc_rd_en,
  output logic [DPTR_W-1:0]     desc_rd_addr,
  input  logic [DESC_W-1:0]     desc_rd_data,
  output logic                  desc_wr_en,
  output logic [DPTR_W-1:0]     desc_wr_addr,
  output logic [DESC_W-1:0]     desc_wr_data,
  output logic                  mem_rd_en,
  output logic [BUF_AW-1:0]     mem_rd_addr,
  input  logic [BYTE_W-1:0]     mem_rd_data,
  output logic                  tx_valid,
  output logic [BYTE_W-1:0]     tx_data,
  output logic                  tx_last,
  input  logic                  tx_ready
);
  eng_state_t state, state_nx;
  desc_t      fetched, held;
  logic       remain_zero;
  logic       close_now;

  assign fetched   = desc_t'(desc_rd_data);
  assign close_now = (state == ST_CLOSE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (cfg_enable) state_nx = ST_DREQ;
      ST_DREQ:  state_nx = cfg_enable ? ST_DWAIT : ST_IDLE;
      ST_DWAIT: begin
        if (!fetched.ready)          state_nx = cfg_enable ? ST_DREQ : ST_IDLE;
        else if (fetched.len == '0)  state_nx = ST_CLOSE;
        else                         state_nx = ST_BREQ;
      end
      ST_BREQ:  state_nx = ST_BWAIT;
      ST_BWAIT: state_nx = ST_BSEND;
      ST_BSEND: if (tx_valid && tx_ready) state_nx = remain_zero ? ST_CLOSE : ST_BREQ;
      ST_CLOSE: state_nx = ST_DREQ;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      held  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_DWAIT) held <= fetched;
    end
  end

  tdr_ptr #(.DPTR_W(DPTR_W)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .base       (cfg_ring_base),
    .host_we    (host_ptr_we),
    .host_ok    (state == ST_IDLE && !cfg_enable),
    .host_wdata (host_ptr_wdata),
    .adv        (close_now),
    .wrap_flag  (held.wrap),
    .ptr        (desc_ptr)
  );

  tdr_fetch #(.AW(BUF_AW), .LW(LEN_W)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .load        (state == ST_DWAIT && fetched.ready),
    .ld_addr     (fetched.buf_addr),
    .ld_len      (fetched.len),
    .step        (state == ST_BREQ),
    .rd_addr     (mem_rd_addr),
    .remain_zero (remain_zero)
  );

  tdr_txreg #(.DW(BYTE_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load    (state == ST_BWAIT),
    .ld_data (mem_rd_data),
    .ld_last (held.eof && remain_zero),
    .ready   (tx_ready),
    .valid   (tx_valid),
    .data    (tx_data),
    .last    (tx_last)
  );

  always_comb begin
    desc_t wb;
    wb           = held;
    wb.ready     = 1'b0;
    desc_wr_data = DESC_W'(wb);
  end

  assign desc_rd_en   = (state == ST_DREQ);
  assign desc_rd_addr = desc_ptr;
  assign desc_wr_en   = close_now;
  assign desc_wr_addr = desc_ptr;
  assign mem_rd_en    = (state == ST_BREQ);
endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk #(
  parameter int DPTR_W = 3,
  parameter int DESC_W = 51,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic [DPTR_W-1:0] cfg_ring_base,
  input logic              host_ptr_we,
  input logic [DPTR_W-1:0] desc_ptr,
  input logic              desc_wr_en,
  input logic [DESC_W-1:0] desc_wr_data,
  input logic              mem_rd_en,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_last,
  input logic              tx_ready
);
  // R5: a stalled byte keeps its value and marker
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R7: a write-back always carries a cleared ready bit
  assert_wb_clear_R7: assert property (@(posedge clk) disable iff (rst)
    desc_wr_en |-> !desc_wr_data[DESC_W-1]);

  // R4: only one byte request in flight
  assert_single_read_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R11: pointer writes while enabled are dropped
  assert_host_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    host_ptr_we && cfg_enable && !desc_wr_en |=> $stable(desc_ptr));

  // R10: a wrap-flagged entry sends the pointer back to the base
  assert_wrap_base_R10: assert property (@(posedge clk) disable iff (rst)
    desc_wr_en && desc_wr_data[DESC_W-2] |=> desc_ptr == $past(cfg_ring_base));
endmodule

bind tdr_engine tdr_engine_chk #(
  .DPTR_W(DPTR_W), .DESC_W(tdr_pkg::DESC_W), .BYTE_W(tdr_pkg::BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
  .host_ptr_we(host_ptr_we), .desc_ptr(desc_ptr), .desc_wr_en(desc_wr_en),
  .desc_wr_data(desc_wr_data), .mem_rd_en(mem_rd_en), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/tdr_engine_bench.sv
module tdr_engine_bench;
  localparam int PW = 3;
  localparam int DW = 51;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0;
  logic [PW-1:0] cfg_ring_base = 3'd2;
  logic host_ptr_we = 1'b0;
  logic [PW-1:0] host_ptr_wdata = '0;
  logic [PW-1:0] desc_ptr, desc_rd_addr, desc_wr_addr;
  logic desc_rd_en, desc_wr_en, mem_rd_en;
  logic [DW-1:0] desc_rd_data = '0;
  logic [DW-1:0] desc_wr_data;
  logic [31:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;

  always #4 clk = ~clk;

  tdr_engine #(.DPTR_W(PW)) u_tdr_engine (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
    .host_ptr_we(host_ptr_we), .host_ptr_wdata(host_ptr_wdata), .desc_ptr(desc_ptr),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .desc_wr_en(desc_wr_en), .desc_wr_addr(desc_wr_addr), .desc_wr_data(desc_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int checks = 0;
  int errors = 0;
  int mem_reads = 0;
  int desc_reads = 0;
  int desc_writes = 0;

  logic [DW-1:0] dmem [8];
  logic [8:0]  exp_bytes [$];
  logic [31:0] exp_addrs [$];
  logic [PW+DW-1:0] exp_wbs [$];

  function automatic logic [7:0] pattern(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory models: one cycle latency (R4)
  always @(posedge clk) begin
    if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr];
    if (desc_wr_en) dmem[desc_wr_addr] <= desc_wr_data;
    if (mem_rd_en)  mem_rd_data <= pattern(mem_rd_addr);
  end

  logic [7:0] lfsr = 8'h5B;
  always @(posedge clk) begin
    #1;
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= lfsr[0] | lfsr[3];
  end

  // per-clock comparison against the reference expectations
  logic prev_stall = 1'b0;
  logic prev_mrd = 1'b0;
  logic [8:0] prev_out = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) chk(tx_valid && {tx_last, tx_data} == prev_out, "R5 hold", {tx_valid, tx_last, tx_data}, {1'b1, prev_out});
      if (prev_mrd && mem_rd_en) chk(1'b0, "R4 back-to-back read", 1, 0);
      if (tx_valid && tx_ready) begin
        if (exp_bytes.size() == 0) chk(1'b0, "R3 unexpected byte", tx_data, 0);
        else begin
          logic [8:0] e;
          e = exp_bytes.pop_front();
          chk(tx_data == e[7:0], "R3 byte", tx_data, e[7:0]);
          chk(tx_last == e[8], "R6 eof marker", tx_last, e[8]);
        end
      end
      if (mem_rd_en) begin
        mem_reads++;
        if (exp_addrs.size() == 0) chk(1'b0, "R3 unexpected read", mem_rd_addr, 0);
        else begin
          logic [31:0] ea;
          ea = exp_addrs.pop_front();
          chk(mem_rd_addr == ea, "R3 read address", mem_rd_addr, ea);
        end
      end
      if (desc_rd_en) desc_reads++;
      if (desc_wr_en) begin
        desc_writes++;
        if (exp_wbs.size() == 0) chk(1'b0, "R7 unexpected write-back", {desc_wr_addr, desc_wr_data}, 0);
        else begin
          logic [PW+DW-1:0] ew;
          ew = exp_wbs.pop_front();
          chk({desc_wr_addr, desc_wr_data} == ew, "R7 write-back", {desc_wr_addr, desc_wr_data}, ew);
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_out   = {tx_last, tx_data};
      prev_mrd   = mem_rd_en;
    end
  end

  // R2: word = {ready[50], wrap[49], eof[48], len[47:32], addr[31:0]}
  task automatic arm(input int idx, input bit wrap, input bit eof, input int len, input logic [31:0] addr);
    dmem[idx] = {1'b1, wrap, eof, len[15:0], addr};
    for (int i = 0; i < len; i++) begin
      exp_addrs.push_back(addr + 32'(i));
      exp_bytes.push_back({eof && (i == len - 1), pattern(addr + 32'(i))});
    end
    exp_wbs.push_back({PW'(idx), 1'b0, wrap, eof, len[15:0], addr});
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((exp_bytes.size() + exp_addrs.size() + exp_wbs.size()) != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk(1'b0, {tag, " drain timeout"}, n, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int snap_w, snap_m, snap_d;
    for (int i = 0; i < 8; i++) dmem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(desc_ptr == 3'd2, "R1 pointer at base", desc_ptr, 2);
    chk(!tx_valid && !mem_rd_en && !desc_rd_en, "R1 quiet", {tx_valid, mem_rd_en, desc_rd_en}, 0);

    // ring 2..5, zero length at 4, wrap at 5
    arm(2, 0, 0, 3, 32'h0000_1000);
    arm(3, 0, 1, 2, 32'h0000_20FE);
    arm(4, 0, 1, 0, 32'h0000_3000);  // R8 zero length
    arm(5, 1, 1, 1, 32'hFFFF_FFF0);
    cfg_enable = 1'b1;
    drain("R3");
    chk(mem_reads == 6, "R8 no reads for empty buffer", mem_reads, 6);
    chk(desc_ptr == 3'd2, "R10 wrap flag returns to base", desc_ptr, 2);

    // R9: entry 2 now not ready; engine polls
    snap_w = desc_writes; snap_m = mem_reads;
    repeat (20) @(negedge clk);
    chk(desc_writes == snap_w && mem_reads == snap_m, "R9 no activity on idle entry", desc_writes - snap_w, 0);
    chk(desc_ptr == 3'd2 && !tx_valid, "R9 pointer held", desc_ptr, 2);

    // becomes ready while polled
    arm(2, 0, 1, 4, 32'h0000_0300);
    drain("R9");
    chk(desc_ptr == 3'd3, "R10 pointer advances by one", desc_ptr, 3);

    // R11: write while enabled is ignored
    host_ptr_we = 1'b1; host_ptr_wdata = 3'd6;
    @(negedge clk);
    host_ptr_we = 1'b0;
    @(negedge clk);
    chk(desc_ptr == 3'd3, "R11 write ignored while enabled", desc_ptr, 3);

    // R12: disabled engine stays quiet
    cfg_enable = 1'b0;
    repeat (4) @(negedge clk);
    snap_d = desc_reads; snap_m = mem_reads;
    repeat (10) @(negedge clk);
    chk(desc_reads == snap_d && mem_reads == snap_m, "R12 no reads when disabled", desc_reads - snap_d, 0);

    // R11: write accepted while disabled
    host_ptr_we = 1'b1; host_ptr_wdata = 3'd7;
    @(negedge clk);
    host_ptr_we = 1'b0;
    @(negedge clk);
    chk(desc_ptr == 3'd7, "R11 write taken while disabled", desc_ptr, 7);

    // top slot without wrap flag
    arm(7, 0, 1, 2, 32'h4000_0010);
    cfg_enable = 1'b1;
    drain("R10");
    chk(desc_ptr == 3'd2, "R10 table end returns to base", desc_ptr, 2);
    chk(dmem[7][50] == 1'b0, "R7 ready cleared in memory", dmem[7][50], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule